// File: doc/BRIEF.md
# Arbitrated Dual-Port Byte-Write RAM

A true two-port static memory of 2048 words of 16 bits. The left and right sides each have a chip enable, an output enable, an 11-bit address, write data, registered read data and a byte-enable pair. With the byte-enable pair a caller can write the low byte, the high byte or the whole word. The two sides work independently. Each can read or write any word, and both can write in the same cycle as long as they do not collide.

When both sides select the same word in one cycle and at least one of them is writing, on-chip arbitration picks a winner. It raises a busy flag toward the loser and drops the loser's write. A role input chooses between two modes. In master mode the block arbitrates and drives the flags. In slave mode it does no arbitration: busy flags supplied from outside gate the writes, so several devices can be ganged into one wider word and stay consistent with a single master.

All control inputs are active high. The model runs on one clock with an asynchronous active-low reset.

Top module: `twinport_arb_ram`

## Requirements
- R1: A word written through either side is returned by a read of that address on either side. Read data appears on the clock edge after the address is presented. A read in the same cycle as a write to that word returns the previously stored value.
- R2: Byte-enable bit 0 writes data bits 7:0 and bit 1 writes bits 15:8. A byte whose enable is low keeps its stored value.
- R3: While a side's chip enable is low, that side writes nothing whatever its enables. Its read data is zero from the next edge on.
- R4: While a side's output enable is low, its read data is zero from the next edge on.
- R5: Without contention, both sides may write different words in the same cycle, and both writes take effect.
- R6: Contention means both chip enables are high, the two addresses are equal and at least one byte enable is high, all in the same cycle. In master mode exactly one busy flag is high during contention and none otherwise. The flags follow the current inputs within the same cycle.
- R7: When contention arises and the right side did not hold that address in the previous cycle, the left side wins and the right busy flag rises. A side holds an address when its chip enable was high with that address.
- R8: When the right side held the address in the previous cycle and the left did not, the right side wins and the left busy flag rises. If both held it, the left side wins.
- R9: The side that loses arbitration has its write dropped. Its read in that cycle still returns the stored data.
- R10: With slave_mode = 1 there is no arbitration and both busy outputs stay low. A high l_busy_i or r_busy_i drops that side's write for the cycle. When both sides write the same byte with no busy input high, the right side's value is stored.
- R11: During and right after reset, both read data outputs are zero and both busy outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slave_mode | input | 1 | 0 = master (arbitrate), 1 = slave (busy from outside) |
| l_ce | input | 1 | Left chip enable |
| l_oe | input | 1 | Left output enable |
| l_addr | input | 11 | Left word address |
| l_wbe | input | 2 | Left byte enables (bit 0 = low byte) |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left registered read data |
| l_busy_i | input | 1 | Left busy from a master (slave mode) |
| l_busy_o | output | 1 | Left busy flag (master mode) |
| r_ce | input | 1 | Right chip enable |
| r_oe | input | 1 | Right output enable |
| r_addr | input | 11 | Right word address |
| r_wbe | input | 2 | Right byte enables (bit 0 = low byte) |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right registered read data |
| r_busy_i | input | 1 | Right busy from a master (slave mode) |
| r_busy_o | output | 1 | Right busy flag (master mode) |

## Verification
The bench builds the block with its default parameters: an 11-bit address, 16-bit words and 8-bit bytes. The full address range is therefore in reach, including word 0x7FF at the top. With two byte lanes, every partial-write combination gets covered. A single vector walk switches between master and slave roles, so fresh contention, held-address ownership, both-held ties and externally forced busy all occur against the same stored contents.

// File: rtl/twinport_pkg.sv
package twinport_pkg;

    typedef enum logic {
        ROLE_MASTER = 1'b0,
        ROLE_SLAVE  = 1'b1
    } role_e;

    localparam int DEF_ADDR_W = 11;
    localparam int DEF_DATA_W = 16;
    localparam int DEF_BYTE_W = 8;

endpackage

// File: rtl/twinport_arbiter.sv
module twinport_arbiter
    import twinport_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int NBYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  role_e             role,
    input  logic              l_ce,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [NBYTES-1:0] l_wbe,
    input  logic              l_busy_i,
    input  logic              r_ce,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [NBYTES-1:0] r_wbe,
    input  logic              r_busy_i,
    output logic              l_busy_o,
    output logic              r_busy_o,
    output logic              l_block,
    output logic              r_block
);

    // previous-cycle access record of each side
    typedef struct packed {
        logic              lv;
        logic [ADDR_W-1:0] la;
        logic              rv;
        logic [ADDR_W-1:0] ra;
    } hold_t;

    hold_t hold_d, hold_q;

    logic clash, l_held, r_held, right_wins, arb_l, arb_r;

    always_comb begin
        clash      = l_ce && r_ce && (l_addr == r_addr) && ((|l_wbe) || (|r_wbe));
        l_held     = hold_q.lv && (hold_q.la == l_addr);
        r_held     = hold_q.rv && (hold_q.ra == r_addr);
        right_wins = r_held && !l_held;
        arb_l      = (role == ROLE_MASTER) && clash && right_wins;
        arb_r      = (role == ROLE_MASTER) && clash && !right_wins;
        l_busy_o   = arb_l;
        r_busy_o   = arb_r;
        l_block    = (role == ROLE_SLAVE) ? l_busy_i : arb_l;
        r_block    = (role == ROLE_SLAVE) ? r_busy_i : arb_r;
        hold_d.lv  = l_ce;
        hold_d.la  = l_addr;
        hold_d.rv  = r_ce;
        hold_d.ra  = r_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

endmodule

// File: rtl/twinport_wr_gate.sv
module twinport_wr_gate #(
    parameter int NBYTES = 2
) (
    input  logic              ce,
    input  logic              block,
    input  logic [NBYTES-1:0] wbe,
    output logic [NBYTES-1:0] we
);

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign we[b] = ce && wbe[b] && !block;
    end

endmodule

// File: rtl/twinport_store.sv
module twinport_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    localparam int NBYTES = DATA_W / BYTE_W,
    localparam int DEPTH  = 2 ** ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_rd,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [NBYTES-1:0] l_we,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_rd,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [NBYTES-1:0] r_we,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);

    typedef struct packed {
        logic [DATA_W-1:0] l;
        logic [DATA_W-1:0] r;
    } rd_t;

    logic [DATA_W-1:0] mem [DEPTH];
    rd_t rd_d, rd_q;

    // right lane assigned after left, so it prevails on an unarbitrated tie
    always_ff @(posedge clk) begin
        for (int b = 0; b < NBYTES; b++) begin
            if (l_we[b]) mem[l_addr][b*BYTE_W +: BYTE_W] <= l_wdata[b*BYTE_W +: BYTE_W];
            if (r_we[b]) mem[r_addr][b*BYTE_W +: BYTE_W] <= r_wdata[b*BYTE_W +: BYTE_W];
        end
    end

    always_comb begin
        rd_d.l = l_rd ? mem[l_addr] : '0;
        rd_d.r = r_rd ? mem[r_addr] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign l_rdata = rd_q.l;
    assign r_rdata = rd_q.r;

endmodule

// File: rtl/twinport_arb_ram.sv
module twinport_arb_ram
    import twinport_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int BYTE_W = DEF_BYTE_W,
    localparam int NBYTES = DATA_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              l_ce,
    input  logic              l_oe,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [NBYTES-1:0] l_wbe,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              l_busy_i,
    output logic              l_busy_o,
    input  logic              r_ce,
    input  logic              r_oe,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [NBYTES-1:0] r_wbe,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    input  logic              r_busy_i,
    output logic              r_busy_o
);

    role_e             role;
    logic              l_block, r_block;
    logic [NBYTES-1:0] l_we, r_we;

    assign role = slave_mode ? ROLE_SLAVE : ROLE_MASTER;

    twinport_arbiter #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .role     (role),
        .l_ce     (l_ce),
        .l_addr   (l_addr),
        .l_wbe    (l_wbe),
        .l_busy_i (l_busy_i),
        .r_ce     (r_ce),
        .r_addr   (r_addr),
        .r_wbe    (r_wbe),
        .r_busy_i (r_busy_i),
        .l_busy_o (l_busy_o),
        .r_busy_o (r_busy_o),
        .l_block  (l_block),
        .r_block  (r_block)
    );

    twinport_wr_gate #(.NBYTES(NBYTES)) u_gate_l (
        .ce    (l_ce),
        .block (l_block),
        .wbe   (l_wbe),
        .we    (l_we)
    );

    twinport_wr_gate #(.NBYTES(NBYTES)) u_gate_r (
        .ce    (r_ce),
        .block (r_block),
        .wbe   (r_wbe),
        .we    (r_we)
    );

    twinport_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .l_rd    (l_ce && l_oe),
        .l_addr  (l_addr),
        .l_we    (l_we),
        .l_wdata (l_wdata),
        .l_rdata (l_rdata),
        .r_rd    (r_ce && r_oe),
        .r_addr  (r_addr),
        .r_we    (r_we),
        .r_wdata (r_wdata),
        .r_rdata (r_rdata)
    );

endmodule

// File: rtl/twinport_checker.sv
module twinport_checker #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16,
    parameter int NBYTES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slave_mode,
    input logic              l_ce,
    input logic              l_oe,
    input logic [ADDR_W-1:0] l_addr,
    input logic [NBYTES-1:0] l_wbe,
    input logic [DATA_W-1:0] l_rdata,
    input logic              l_busy_o,
    input logic              r_ce,
    input logic              r_oe,
    input logic [ADDR_W-1:0] r_addr,
    input logic [NBYTES-1:0] r_wbe,
    input logic [DATA_W-1:0] r_rdata,
    input logic              r_busy_o
);

    logic contend;
    assign contend = l_ce && r_ce && (l_addr == r_addr) && ((l_wbe != '0) || (r_wbe != '0));

    p_busy_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_busy_o && r_busy_o));

    p_busy_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (l_busy_o || r_busy_o) |-> contend);

    p_one_loser_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && contend) |-> ($countones({l_busy_o, r_busy_o}) == 1));

    p_fresh_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && contend && !($past(r_ce) && ($past(r_addr) == r_addr))) |-> r_busy_o);

    p_slave_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |-> (!l_busy_o && !r_busy_o));

    p_l_deselect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !l_ce |=> (l_rdata == '0));

    p_r_deselect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !r_ce |=> (r_rdata == '0));

    p_l_oe_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !l_oe |=> (l_rdata == '0));

    p_r_oe_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !r_oe |=> (r_rdata == '0));

endmodule

bind twinport_arb_ram twinport_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NBYTES (NBYTES)
) u_chk (.*);

// File: tb/twinport_arb_ram_tb_top.sv
`timescale 1ns/1ps
module twinport_arb_ram_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slave_mode = 1'b0;
    logic        l_ce = 1'b0, l_oe = 1'b0, l_busy_i = 1'b0;
    logic [10:0] l_addr = '0;
    logic [1:0]  l_wbe = '0;
    logic [15:0] l_wdata = '0;
    logic        r_ce = 1'b0, r_oe = 1'b0, r_busy_i = 1'b0;
    logic [10:0] r_addr = '0;
    logic [1:0]  r_wbe = '0;
    logic [15:0] r_wdata = '0;
    logic [15:0] l_rdata, r_rdata;
    logic        l_busy_o, r_busy_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    twinport_arb_ram dut_i (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .l_ce(l_ce), .l_oe(l_oe), .l_addr(l_addr), .l_wbe(l_wbe), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_busy_i(l_busy_i), .l_busy_o(l_busy_o),
        .r_ce(r_ce), .r_oe(r_oe), .r_addr(r_addr), .r_wbe(r_wbe), .r_wdata(r_wdata),
        .r_rdata(r_rdata), .r_busy_i(r_busy_i), .r_busy_o(r_busy_o)
    );

    typedef struct packed {
        logic        slv;
        logic        lce;
        logic        loe;
        logic [1:0]  lbe;
        logic [10:0] la;
        logic [15:0] lwd;
        logic        rce;
        logic        roe;
        logic [1:0]  rbe;
        logic [10:0] ra;
        logic [15:0] rwd;
        logic        xlb;
        logic        xrb;
        logic        elb;
        logic        erb;
        logic [15:0] elr;
        logic [15:0] err;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        // R5: two writes at different words together
        '{1'b0, 1'b1,1'b0,2'b11,11'h005,16'h1234, 1'b1,1'b0,2'b11,11'h7FF,16'hBEEF, 1'b0,1'b0, 1'b0,1'b0, 16'h0000,16'h0000, 4'd5},
        // R1: cross reads, including top word
        '{1'b0, 1'b1,1'b1,2'b00,11'h7FF,16'h0000, 1'b1,1'b1,2'b00,11'h005,16'h0000, 1'b0,1'b0, 1'b0,1'b0, 16'hBEEF,16'h1234, 4'd1},
        // R2: low byte only; read returns old word
        '{1'b0, 1'b1,1'b1,2'b01,11'h005,16'hAAAA, 1'b0,1'b1,2'b00,11'h000,16'h0000, 1'b0,1'b0, 1'b0,1'b0, 16'h1234,16'h0000, 4'd2},
        // R4: left oe low; high byte only
        '{1'b0, 1'b1,1'b0,2'b10,11'h005,16'h5555, 1'b1,1'b1,2'b00,11'h7FF,16'h0000, 1'b0,1'b0, 1'b0,1'b0, 16'h0000,16'hBEEF, 4'd4},
        // R3: right deselected with enables high
        '{1'b0, 1'b1,1'b0,2'b11,11'h100,16'h0F0F, 1'b0,1'b1,2'b11,11'h7FF,16'h0000, 1'b0,1'b0, 1'b0,1'b0, 16'h0000,16'h0000, 4'd3},
        // R3: top word untouched; R2 merged word 55AA
        '{1'b0, 1'b1,1'b1,2'b00,11'h005,16'h0000, 1'b1,1'b1,2'b00,11'h7FF,16'h0000, 1'b0,1'b0, 1'b0,1'b0, 16'h55AA,16'hBEEF, 4'd3},
        // R7: fresh contention, left wins
        '{1'b0, 1'b1,1'b1,2'b11,11'h100,16'h1111, 1'b1,1'b1,2'b11,11'h100,16'h2222, 1'b0,1'b0, 1'b0,1'b1, 16'h0F0F,16'h0F0F, 4'd7},
        // R9: loser dropped; R6 two reads, no busy
        '{1'b0, 1'b1,1'b1,2'b00,11'h100,16'h0000, 1'b1,1'b1,2'b00,11'h100,16'h0000, 1'b0,1'b0, 1'b0,1'b0, 16'h1111,16'h1111, 4'd9},
        // R4: left away with oe low, right keeps holding 0x100
        '{1'b0, 1'b1,1'b0,2'b00,11'h200,16'h0000, 1'b1,1'b1,2'b00,11'h100,16'h0000, 1'b0,1'b0, 1'b0,1'b0, 16'h0000,16'h1111, 4'd4},
        // R8: right held address, right wins
        '{1'b0, 1'b1,1'b1,2'b11,11'h100,16'h3333, 1'b1,1'b1,2'b01,11'h100,16'h4444, 1'b0,1'b0, 1'b1,1'b0, 16'h1111,16'h1111, 4'd8},
        // R9: left write dropped, right low byte kept
        '{1'b0, 1'b1,1'b1,2'b00,11'h100,16'h0000, 1'b1,1'b1,2'b00,11'h100,16'h0000, 1'b0,1'b0, 1'b0,1'b0, 16'h1144,16'h1144, 4'd9},
        // R10: slave, same word both write, right kept
        '{1'b1, 1'b1,1'b0,2'b11,11'h300,16'hAAAA, 1'b1,1'b0,2'b11,11'h300,16'hBBBB, 1'b0,1'b0, 1'b0,1'b0, 16'h0000,16'h0000, 4'd10},
        // R10: slave, external busy drops left write
        '{1'b1, 1'b1,1'b1,2'b11,11'h005,16'h9999, 1'b1,1'b1,2'b00,11'h300,16'h0000, 1'b1,1'b0, 1'b0,1'b0, 16'h55AA,16'hBBBB, 4'd10},
        '{1'b1, 1'b1,1'b1,2'b00,11'h005,16'h0000, 1'b1,1'b0,2'b11,11'h7FF,16'h0001, 1'b0,1'b0, 1'b0,1'b0, 16'h55AA,16'h0000, 4'd10},
        // R1: top word rewritten in slave mode
        '{1'b0, 1'b1,1'b1,2'b00,11'h7FF,16'h0000, 1'b0,1'b0,2'b00,11'h000,16'h0000, 1'b0,1'b0, 1'b0,1'b0, 16'h0001,16'h0000, 4'd1},
        // R7: left writes, right reads, right flagged, right read still old
        '{1'b0, 1'b1,1'b0,2'b11,11'h005,16'h7777, 1'b1,1'b1,2'b00,11'h005,16'h0000, 1'b0,1'b0, 1'b0,1'b1, 16'h0000,16'h55AA, 4'd7},
        '{1'b0, 1'b1,1'b1,2'b00,11'h005,16'h0000, 1'b1,1'b1,2'b00,11'h005,16'h0000, 1'b0,1'b0, 1'b0,1'b0, 16'h7777,16'h7777, 4'd9},
        // R8: both held, left wins
        '{1'b0, 1'b1,1'b1,2'b11,11'h005,16'h8888, 1'b1,1'b1,2'b11,11'h005,16'h9999, 1'b0,1'b0, 1'b0,1'b1, 16'h7777,16'h7777, 4'd8},
        '{1'b0, 1'b1,1'b1,2'b00,11'h005,16'h0000, 1'b1,1'b1,2'b00,11'h005,16'h0000, 1'b0,1'b0, 1'b0,1'b0, 16'h8888,16'h8888, 4'd8}
    };

    task automatic check(input int tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        check(11, "l_rdata in reset", l_rdata, 16'h0);
        check(11, "r_rdata in reset", r_rdata, 16'h0);
        check(11, "busy in reset", {14'h0, l_busy_o, r_busy_o}, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(11, "l_rdata after reset", l_rdata, 16'h0);
        check(11, "r_rdata after reset", r_rdata, 16'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            slave_mode = VECS[i].slv;
            l_ce = VECS[i].lce; l_oe = VECS[i].loe; l_wbe = VECS[i].lbe;
            l_addr = VECS[i].la; l_wdata = VECS[i].lwd; l_busy_i = VECS[i].xlb;
            r_ce = VECS[i].rce; r_oe = VECS[i].roe; r_wbe = VECS[i].rbe;
            r_addr = VECS[i].ra; r_wdata = VECS[i].rwd; r_busy_i = VECS[i].xrb;
            #1;
            check(VECS[i].tag, $sformatf("vec %0d l_busy_o", i), {15'h0, l_busy_o}, {15'h0, VECS[i].elb});
            check(VECS[i].tag, $sformatf("vec %0d r_busy_o", i), {15'h0, r_busy_o}, {15'h0, VECS[i].erb});
            @(posedge clk); #1;
            check(VECS[i].tag, $sformatf("vec %0d l_rdata", i), l_rdata, VECS[i].elr);
            check(VECS[i].tag, $sformatf("vec %0d r_rdata", i), r_rdata, VECS[i].err);
        end

        // R11: reset in mid-run clears nonzero read data
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(11, "l_rdata on reset", l_rdata, 16'h0);
        check(11, "r_rdata on reset", r_rdata, 16'h0);
        l_ce = 1'b0; r_ce = 1'b0; l_wbe = '0; r_wbe = '0;
        #1;
        check(11, "busy idle", {14'h0, l_busy_o, r_busy_o}, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        finish_run();
    end

endmodule